// File: doc/BRIEF.md
# Reset Cause Status Recorder

This block keeps the record of why the processor last restarted or came out of a low-power state. Each source of a restart or a wake raises a one-cycle strobe. The strobes are power-on, brown-out, external clear, configuration mismatch, watchdog expiry, stack overflow, stack underflow, the reset instruction and an interrupt wake. The block also sees the current power mode, the stack-error reset enable and the two global interrupt enables.

The winning event updates eight status flags. Each flag is set, cleared or held, depending on both the event and the power mode the core was in. One cycle later the block emits a pulse that says whether the event was a true reset or a wake, with a code that selects the next program counter. Firmware can re-arm the flags through a write port, so that a later event can be told apart from an earlier one.

Top module: `rstcause_recorder`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), status_o is 8'h3C and evt_valid_o, evt_reset_o and pc_sel_o are all 0. Status bit layout: [0] brown-out clear flag, [1] power-on clear flag, [2] power-down flag, [3] watchdog flag, [4] reset-instruction flag, [5] configuration flag, [6] stack-overflow flag, [7] stack-underflow flag.
- R2: A power-on strobe sets bits [5:2] to 1 and clears bits [1:0] and [7:6], giving status_o = 8'h3C. It is a reset.
- R3: A reset-instruction strobe clears bit 4 and holds every other bit. It is a reset.
- R4: A brown-out strobe sets bits 5 and 4 and clears bit 0. Bits 3, 2, 1, 7 and 6 are held. It is a reset.
- R5: A configuration-mismatch strobe clears bit 5, holds the rest, and is a reset.
- R6: An external-clear strobe sets bit 3. Bit 2 is held when pwr_mode is 00 (full run) or 01 (low-power run), and cleared when pwr_mode is 10 (idle) or 11 (sleep). It is a reset.
- R7: A watchdog strobe clears bit 3. In a run mode it holds bit 2 and is a reset. In idle or sleep it also clears bit 2 and is a wake with pc_sel 01.
- R8: An interrupt-wake strobe in pwr_mode 01, 10 or 11 clears bit 2, holds bit 3, and is a wake. pc_sel is 10 for a high-priority interrupt with gie_high set, 11 for a low-priority interrupt with gie_low set, and 01 otherwise. In pwr_mode 00 it has no effect.
- R9: Stack overflow sets bit 6 and stack underflow sets bit 7. With stk_rst_en = 1 each is a reset. With stk_rst_en = 0 only the flag is set and no pulse is produced.
- R10: With sw_we high and no effective event, each 1 in sw_data[5:0] sets the matching status bit, and a 1 in sw_data[6] or sw_data[7] clears that bit. In a cycle with an effective event, the write is ignored.
- R11: Simultaneous strobes resolve by fixed priority, highest first: power-on, brown-out, external clear, configuration mismatch, watchdog, stack overflow, stack underflow, reset instruction, interrupt wake. Only the winner is applied.
- R12: Flags update at the clock edge that samples the strobe. evt_valid_o pulses for that one following cycle. evt_reset_o is 1 for a reset. pc_sel_o is 00 for every reset (vector 0000h), 01 for the next instruction, 10 for the high vector and 11 for the low vector. Both evt_reset_o and pc_sel_o are 0 when no pulse is produced. With no strobe and no write, the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_power_on | input | 1 | Power-on strobe |
| ev_brownout | input | 1 | Brown-out strobe |
| ev_ext_clear | input | 1 | External clear strobe |
| ev_cfg_mismatch | input | 1 | Configuration mismatch strobe |
| ev_watchdog | input | 1 | Watchdog expiry strobe |
| ev_stk_over | input | 1 | Stack overflow strobe |
| ev_stk_under | input | 1 | Stack underflow strobe |
| ev_rst_instr | input | 1 | Reset instruction strobe |
| ev_int_wake | input | 1 | Interrupt wake strobe |
| int_high_pri | input | 1 | Waking interrupt is high priority |
| gie_high | input | 1 | High-priority global interrupt enable |
| gie_low | input | 1 | Low-priority global interrupt enable |
| pwr_mode | input | 2 | 00 full run, 01 low-power run, 10 idle, 11 sleep |
| stk_rst_en | input | 1 | Stack errors cause a reset |
| sw_we | input | 1 | Firmware write enable |
| sw_data | input | 8 | [5:0] set mask, [7:6] stack flag clear mask |
| status_o | output | 8 | Status flags |
| evt_valid_o | output | 1 | Event pulse |
| evt_reset_o | output | 1 | Event was a reset |
| pc_sel_o | output | 2 | Next program counter select |

## Verification
Every result of this block is due one clock edge after its stimulus. The edge that samples a strobe or a write updates status_o, and the outputs evt_valid_o, evt_reset_o and pc_sel_o change at that same edge. The driver applies each input vector on a falling edge and queues the expected flags and pulse fields at once. The monitor pops one entry 5 ns after every rising edge, so each comparison falls in the single cycle where that result is valid and before the next vector can change it.

// File: rtl/rcr_pkg.sv
// Package: shared constants for the reset cause recorder.
// Assumes event indices double as priority ranks (0 is highest).
package rcr_pkg;
    localparam int NUM_EVT = 9;
    localparam int FLAG_W  = 8;

    localparam int EV_PON  = 0;
    localparam int EV_BRN  = 1;
    localparam int EV_XCLR = 2;
    localparam int EV_CFG  = 3;
    localparam int EV_WDT  = 4;
    localparam int EV_SOVF = 5;
    localparam int EV_SUNF = 6;
    localparam int EV_RSTI = 7;
    localparam int EV_INT  = 8;

    localparam int F_BRN = 0;
    localparam int F_PON = 1;
    localparam int F_PDN = 2;
    localparam int F_WDT = 3;
    localparam int F_SWR = 4;
    localparam int F_CFG = 5;
    localparam int F_SFL = 6;
    localparam int F_SUN = 7;

    localparam logic [FLAG_W-1:0] FLAGS_INIT = 8'h3C;

    typedef enum logic [1:0] {
        PC_RESET = 2'b00,
        PC_NEXT  = 2'b01,
        PC_HIVEC = 2'b10,
        PC_LOVEC = 2'b11
    } pc_sel_t;

    typedef enum logic [1:0] {
        PM_FULL = 2'b00,
        PM_LPRUN = 2'b01,
        PM_IDLE = 2'b10,
        PM_SLEEP = 2'b11
    } pmode_t;
endpackage

// File: rtl/rcr_arbiter.sv
// Fixed-priority arbiter: passes the lowest-index active request.
// Assumes request bit 0 has the highest priority.
module rcr_arbiter #(
    parameter int N = 9
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Walk the requests and block every one below the first hit.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = req[i] & ~blocked;
            blocked  = blocked | req[i];
        end
        any = blocked;
    end
endmodule

// File: rtl/rcr_next.sv
// Next-state logic: maps the granted event and power mode to new flags,
// reset/wake class and program-counter select.
// Assumes grant is one-hot or zero.
module rcr_next
    import rcr_pkg::*;
(
    input  logic [NUM_EVT-1:0] grant,
    input  logic [1:0]         pwr_mode,
    input  logic               stk_rst_en,
    input  logic               int_high_pri,
    input  logic               gie_high,
    input  logic               gie_low,
    input  logic [FLAG_W-1:0]  cur,
    output logic [FLAG_W-1:0]  nxt,
    output logic               hit,
    output logic               pulse,
    output logic               is_reset,
    output logic [1:0]         pc_sel
);
    logic low_pwr_halt;
    logic in_low_pwr;

    // Classify the power mode once for the event rules.
    always_comb begin
        low_pwr_halt = (pwr_mode == PM_IDLE) || (pwr_mode == PM_SLEEP);
        in_low_pwr   = (pwr_mode != PM_FULL);
    end

    // Apply the rule of the single granted event.
    always_comb begin
        nxt      = cur;
        hit      = 1'b1;
        pulse    = 1'b1;
        is_reset = 1'b1;
        pc_sel   = PC_RESET;
        unique case (1'b1)
            grant[EV_PON]: begin
                nxt = FLAGS_INIT;
            end
            grant[EV_BRN]: begin
                nxt[F_CFG] = 1'b1;
                nxt[F_SWR] = 1'b1;
                nxt[F_BRN] = 1'b0;
            end
            grant[EV_XCLR]: begin
                nxt[F_WDT] = 1'b1;
                if (low_pwr_halt) nxt[F_PDN] = 1'b0;
            end
            grant[EV_CFG]: begin
                nxt[F_CFG] = 1'b0;
            end
            grant[EV_WDT]: begin
                nxt[F_WDT] = 1'b0;
                if (low_pwr_halt) begin
                    nxt[F_PDN] = 1'b0;
                    is_reset   = 1'b0;
                    pc_sel     = PC_NEXT;
                end
            end
            grant[EV_SOVF]: begin
                nxt[F_SFL] = 1'b1;
                pulse      = stk_rst_en;
                is_reset   = stk_rst_en;
            end
            grant[EV_SUNF]: begin
                nxt[F_SUN] = 1'b1;
                pulse      = stk_rst_en;
                is_reset   = stk_rst_en;
            end
            grant[EV_RSTI]: begin
                nxt[F_SWR] = 1'b0;
            end
            grant[EV_INT]: begin
                if (in_low_pwr) begin
                    nxt[F_PDN] = 1'b0;
                    is_reset   = 1'b0;
                    if (int_high_pri) pc_sel = gie_high ? PC_HIVEC : PC_NEXT;
                    else              pc_sel = gie_low  ? PC_LOVEC : PC_NEXT;
                end else begin
                    hit      = 1'b0;
                    pulse    = 1'b0;
                    is_reset = 1'b0;
                end
            end
            default: begin
                hit      = 1'b0;
                pulse    = 1'b0;
                is_reset = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rcr_swmerge.sv
// Firmware write merge: sets reset flags and clears stack flags per mask.
// Assumes the caller gives events precedence over this result.
module rcr_swmerge
    import rcr_pkg::*;
(
    input  logic [FLAG_W-1:0] cur,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] merged
);
    localparam int SET_W = F_SFL;

    logic [FLAG_W-1:0] set_mask;
    logic [FLAG_W-1:0] clr_mask;

    // Split the write word into a set mask and a clear mask.
    always_comb begin
        set_mask = {{(FLAG_W-SET_W){1'b0}}, wdata[SET_W-1:0]};
        clr_mask = {wdata[FLAG_W-1:SET_W], {SET_W{1'b0}}};
        merged   = (cur | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/rstcause_recorder.sv
// Top: records the cause of the last restart or wake and emits a
// registered pulse with reset/wake class and next-PC select.
// Assumes all event inputs are one-cycle synchronous strobes.
module rstcause_recorder
    import rcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_power_on,
    input  logic        ev_brownout,
    input  logic        ev_ext_clear,
    input  logic        ev_cfg_mismatch,
    input  logic        ev_watchdog,
    input  logic        ev_stk_over,
    input  logic        ev_stk_under,
    input  logic        ev_rst_instr,
    input  logic        ev_int_wake,
    input  logic        int_high_pri,
    input  logic        gie_high,
    input  logic        gie_low,
    input  logic [1:0]  pwr_mode,
    input  logic        stk_rst_en,
    input  logic        sw_we,
    input  logic [7:0]  sw_data,
    output logic [7:0]  status_o,
    output logic        evt_valid_o,
    output logic        evt_reset_o,
    output logic [1:0]  pc_sel_o
);
    logic [NUM_EVT-1:0] ev_req;
    logic [NUM_EVT-1:0] ev_grant;
    logic               ev_any;
    logic [FLAG_W-1:0]  flags_q;
    logic [FLAG_W-1:0]  flags_evt;
    logic [FLAG_W-1:0]  flags_sw;
    logic               evt_hit;
    logic               evt_pulse;
    logic               evt_is_rst;
    logic [1:0]         evt_pc;

    // Gather the strobes in priority order.
    always_comb begin
        ev_req          = '0;
        ev_req[EV_PON]  = ev_power_on;
        ev_req[EV_BRN]  = ev_brownout;
        ev_req[EV_XCLR] = ev_ext_clear;
        ev_req[EV_CFG]  = ev_cfg_mismatch;
        ev_req[EV_WDT]  = ev_watchdog;
        ev_req[EV_SOVF] = ev_stk_over;
        ev_req[EV_SUNF] = ev_stk_under;
        ev_req[EV_RSTI] = ev_rst_instr;
        ev_req[EV_INT]  = ev_int_wake;
    end

    rcr_arbiter #(.N(NUM_EVT)) u_arb (
        .req   (ev_req),
        .grant (ev_grant),
        .any   (ev_any)
    );

    rcr_next u_next (
        .grant        (ev_grant),
        .pwr_mode     (pwr_mode),
        .stk_rst_en   (stk_rst_en),
        .int_high_pri (int_high_pri),
        .gie_high     (gie_high),
        .gie_low      (gie_low),
        .cur          (flags_q),
        .nxt          (flags_evt),
        .hit          (evt_hit),
        .pulse        (evt_pulse),
        .is_reset     (evt_is_rst),
        .pc_sel       (evt_pc)
    );

    rcr_swmerge u_sw (
        .cur    (flags_q),
        .wdata  (sw_data),
        .merged (flags_sw)
    );

    // Flag register: events win over firmware writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flags_q <= FLAGS_INIT;
        else if (ev_any && evt_hit) flags_q <= flags_evt;
        else if (sw_we)             flags_q <= flags_sw;
    end

    // Output pulse register: one cycle per effective event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid_o <= 1'b0;
            evt_reset_o <= 1'b0;
            pc_sel_o    <= PC_RESET;
        end else begin
            evt_valid_o <= evt_pulse;
            evt_reset_o <= evt_pulse & evt_is_rst;
            pc_sel_o    <= evt_pulse ? evt_pc : PC_RESET;
        end
    end

    assign status_o = flags_q;
endmodule

// File: rtl/rcr_checker.sv
// Checker: temporal properties of the reset cause recorder.
module rcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_power_on,
    input logic       ev_brownout,
    input logic       ev_ext_clear,
    input logic       ev_cfg_mismatch,
    input logic       ev_watchdog,
    input logic       ev_stk_over,
    input logic       ev_stk_under,
    input logic       ev_rst_instr,
    input logic       ev_int_wake,
    input logic [1:0] pwr_mode,
    input logic       stk_rst_en,
    input logic       sw_we,
    input logic [7:0] status_o,
    input logic       evt_valid_o,
    input logic       evt_reset_o,
    input logic [1:0] pc_sel_o
);
    logic above_wdt;
    logic above_sunf;
    logic no_strobe;

    // Helper terms for the priority-gated properties.
    always_comb begin
        above_wdt  = ev_power_on | ev_brownout | ev_ext_clear | ev_cfg_mismatch;
        above_sunf = above_wdt | ev_watchdog | ev_stk_over;
        no_strobe  = ~(above_sunf | ev_stk_under | ev_rst_instr | ev_int_wake);
    end

    AST_PON_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_power_on |=> (status_o == 8'h3C && evt_valid_o && evt_reset_o)); // R2

    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reset_o |-> (evt_valid_o && pc_sel_o == 2'b00)); // R12

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !sw_we) |=> (!evt_valid_o && $stable(status_o))); // R12

    AST_WDT_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_watchdog && !above_wdt && pwr_mode[1])
        |=> (evt_valid_o && !evt_reset_o && pc_sel_o == 2'b01
             && !status_o[3] && !status_o[2])); // R7

    AST_SUNF_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stk_under && !above_sunf && !stk_rst_en)
        |=> (!evt_valid_o && status_o[7])); // R9

    AST_INT_FULLRUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_int_wake && !above_sunf && !ev_stk_under && !ev_rst_instr
         && pwr_mode == 2'b00 && !sw_we)
        |=> (!evt_valid_o && $stable(status_o))); // R8
endmodule

bind rstcause_recorder rcr_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_power_on     (ev_power_on),
    .ev_brownout     (ev_brownout),
    .ev_ext_clear    (ev_ext_clear),
    .ev_cfg_mismatch (ev_cfg_mismatch),
    .ev_watchdog     (ev_watchdog),
    .ev_stk_over     (ev_stk_over),
    .ev_stk_under    (ev_stk_under),
    .ev_rst_instr    (ev_rst_instr),
    .ev_int_wake     (ev_int_wake),
    .pwr_mode        (pwr_mode),
    .stk_rst_en      (stk_rst_en),
    .sw_we           (sw_we),
    .status_o        (status_o),
    .evt_valid_o     (evt_valid_o),
    .evt_reset_o     (evt_reset_o),
    .pc_sel_o        (pc_sel_o)
);

// File: tb/rstcause_recorder_test.sv
// Scoreboard bench: driver queues expectations, monitor compares them.
module rstcause_recorder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] ev = '0;
    logic int_high_pri = 0, gie_high = 0, gie_low = 0, stk_rst_en = 0, sw_we = 0;
    logic [1:0] pwr_mode = 2'b00;
    logic [7:0] sw_data = '0;
    logic [7:0] status_o;
    logic evt_valid_o, evt_reset_o;
    logic [1:0] pc_sel_o;

    typedef struct packed {
        logic       v;
        logic       r;
        logic [1:0] pc;
        logic [7:0] st;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [7:0] model_st = 8'h3C;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rstcause_recorder uut (
        .clk(clk), .rst_n(rst_n),
        .ev_power_on(ev[0]), .ev_brownout(ev[1]), .ev_ext_clear(ev[2]),
        .ev_cfg_mismatch(ev[3]), .ev_watchdog(ev[4]), .ev_stk_over(ev[5]),
        .ev_stk_under(ev[6]), .ev_rst_instr(ev[7]), .ev_int_wake(ev[8]),
        .int_high_pri(int_high_pri), .gie_high(gie_high), .gie_low(gie_low),
        .pwr_mode(pwr_mode), .stk_rst_en(stk_rst_en), .sw_we(sw_we),
        .sw_data(sw_data), .status_o(status_o), .evt_valid_o(evt_valid_o),
        .evt_reset_o(evt_reset_o), .pc_sel_o(pc_sel_o)
    );

    // Driver: apply one vector on a falling edge and queue its expectation.
    task automatic apply(input logic [8:0] e, input logic [1:0] m, input logic sen,
                         input logic ihp, input logic gh, input logic gl,
                         input logic we, input logic [7:0] wd, input string tag);
        exp_t x;
        logic [7:0] s;
        s = model_st;
        x = '0;
        if (e[0]) begin s = 8'h3C; x.v = 1; x.r = 1; end
        else if (e[1]) begin s[5] = 1; s[4] = 1; s[0] = 0; x.v = 1; x.r = 1; end
        else if (e[2]) begin s[3] = 1; if (m >= 2) s[2] = 0; x.v = 1; x.r = 1; end
        else if (e[3]) begin s[5] = 0; x.v = 1; x.r = 1; end
        else if (e[4]) begin
            s[3] = 0; x.v = 1;
            if (m >= 2) begin s[2] = 0; x.pc = 2'b01; end else x.r = 1;
        end
        else if (e[5]) begin s[6] = 1; x.v = sen; x.r = sen; end
        else if (e[6]) begin s[7] = 1; x.v = sen; x.r = sen; end
        else if (e[7]) begin s[4] = 0; x.v = 1; x.r = 1; end
        else if (e[8] && m != 2'b00) begin
            s[2] = 0; x.v = 1;
            x.pc = ihp ? (gh ? 2'b10 : 2'b01) : (gl ? 2'b11 : 2'b01);
        end
        else if (we) begin
            s = s | {2'b00, wd[5:0]};
            s = s & ~{wd[7:6], 6'b0};
        end
        x.st = s;
        model_st = s;
        @(negedge clk);
        ev = e; pwr_mode = m; stk_rst_en = sen; int_high_pri = ihp;
        gie_high = gh; gie_low = gl; sw_we = we; sw_data = wd;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued expectation 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({evt_valid_o, evt_reset_o, pc_sel_o, status_o} !== x) begin
                fails++;
                $display("FAIL %s: got v=%b r=%b pc=%b st=%h, expected v=%b r=%b pc=%b st=%h",
                         t, evt_valid_o, evt_reset_o, pc_sel_o, status_o,
                         x.v, x.r, x.pc, x.st);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if ({evt_valid_o, evt_reset_o, pc_sel_o, status_o} !== {4'b0, 8'h3C}) begin
            fails++;
            $display("FAIL R1: got %b_%h, expected 0000_3c",
                     {evt_valid_o, evt_reset_o, pc_sel_o}, status_o);
        end
        rst_n = 1'b1;
        // R12 idle hold, then R10 write clears/sets
        apply(9'h000, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R12 idle");
        apply(9'h001 << 6, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R9 underflow no reset");
        apply(9'h001 << 5, 2'b00, 1, 0, 0, 0, 0, 8'h00, "R9 overflow reset");
        apply(9'h000, 2'b00, 0, 0, 0, 0, 1, 8'h40, "R10 clear overflow flag");
        apply(9'h001 << 7, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R3 reset instruction");
        apply(9'h001 << 1, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R4 brown-out");
        apply(9'h000, 2'b00, 0, 0, 0, 0, 1, 8'h83, "R10 set pon/brn clear under");
        apply(9'h001 << 3, 2'b01, 0, 0, 0, 0, 0, 8'h00, "R5 config mismatch");
        apply(9'h001 << 4, 2'b01, 0, 0, 0, 0, 0, 8'h00, "R7 watchdog run");
        apply(9'h001 << 2, 2'b01, 0, 0, 0, 0, 0, 8'h00, "R6 ext clear run");
        apply(9'h001 << 4, 2'b11, 0, 0, 0, 0, 0, 8'h00, "R7 watchdog sleep");
        apply(9'h000, 2'b00, 0, 0, 0, 0, 1, 8'h3F, "R10 set all");
        apply(9'h001 << 2, 2'b10, 0, 0, 0, 0, 0, 8'h00, "R6 ext clear idle");
        apply(9'h000, 2'b00, 0, 0, 0, 0, 1, 8'h04, "R10 set pdn");
        apply(9'h001 << 8, 2'b00, 0, 1, 1, 1, 0, 8'h00, "R8 wake in full run ignored");
        apply(9'h001 << 8, 2'b10, 0, 1, 1, 0, 0, 8'h00, "R8 high vector");
        apply(9'h001 << 8, 2'b11, 0, 0, 0, 1, 0, 8'h00, "R8 low vector");
        apply(9'h001 << 8, 2'b01, 0, 1, 0, 1, 0, 8'h00, "R8 gie off next instr");
        apply(9'h001 << 3, 2'b00, 0, 0, 0, 0, 1, 8'h20, "R10 write overridden");
        apply(9'h011, 2'b11, 0, 0, 0, 0, 0, 8'h00, "R11 pon beats watchdog");
        apply(9'h018, 2'b11, 0, 0, 0, 0, 0, 8'h00, "R11 cfg beats watchdog");
        apply(9'h190, 2'b11, 0, 0, 0, 0, 0, 8'h00, "R11 watchdog beats rsti/int");
        apply(9'h0C0, 2'b00, 1, 0, 0, 0, 0, 8'h00, "R11 underflow beats rsti");
        apply(9'h001, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R2 power-on");
        apply(9'h000, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R12 pulse ends");
        @(negedge clk);
        ev = '0; sw_we = 0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule